// File: doc/BRIEF.md
# Cache maintenance range splitter

The block accepts one maintenance request at a time. A request carries a byte start address, an exclusive byte end address and an operation: invalidate, clean or flush. The block breaks it into a series of commands for a downstream cache maintenance engine. There are two kinds of command. A single-line clean-and-invalidate covers one line. A range command, either clean or invalidate, covers an inclusive span of whole lines.

Lines that a request only partly covers are handled according to the operation. An invalidate request must not discard bytes that lie outside the request. Its partial edge lines are therefore cleaned and invalidated one by one, and the invalidate ranges then cover only the whole lines in between. Clean and flush requests widen the span outward to line boundaries. Every range command stays within a size cap and never crosses a page edge.

A write-through override input, sampled when a request is accepted, drops every clean range. With the override set, a clean request emits nothing and a flush request emits only invalidate ranges. After the final command of each request, and also for a request that produced no commands, the block raises a one-cycle completion pulse that the host uses as a barrier.

Top module: `cache_range_splitter`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle and stays high until the cycle of the completion pulse. A `req_valid` presented while `busy` is high has no effect.
- R2: Operation codes on `req_op` are 0 = invalidate, 1 = clean, 2 = flush, and 3 behaves as flush. Command kinds on `cmd_kind` are 0 = single-line clean+invalidate, 1 = clean range and 2 = invalidate range. `cmd_addr` holds the first line address and `cmd_last` the address of the last line, inclusive. For a single-line command the two are equal.
- R3: For invalidate, a start that is not line-aligned produces a single-line command for the line that holds the start. Processing then continues from the next line boundary.
- R4: For invalidate, if the adjusted start is still below the end and the end is not line-aligned, a single-line command is issued for the line that holds the end. The end is then rounded down to a line boundary.
- R5: For clean and flush, the start is rounded down and the end rounded up to the 32-byte line boundary.
- R6: A range command covers at most 1024 bytes, so `cmd_last - cmd_addr` is at most 992.
- R7: A range command never crosses a 4 KiB page boundary.
- R8: With the override set when the request is taken, a clean request emits no commands and a flush request emits only invalidate ranges.
- R9: Without the override, a flush request emits, for each chunk, a clean range followed by an invalidate range over the same lines.
- R10: `done_pulse` is high for exactly one cycle, in the cycle after the edge that completes the handshake of the final command. For a request with no commands it appears two cycles after acceptance.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind`, `cmd_addr` and `cmd_last` hold their values.
- R12: Commands are issued in this order: the head line, then the tail line, then the chunks in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code |
| req_start | input | ADDR_W | First byte address |
| req_end | input | ADDR_W | Exclusive end byte address |
| wt_override | input | 1 | Write-through override, sampled on accept |
| busy | output | 1 | Request in progress |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_kind | output | 2 | Command kind |
| cmd_addr | output | ADDR_W | First line address |
| cmd_last | output | ADDR_W | Last line address, inclusive |
| done_pulse | output | 1 | Completion barrier pulse |

## Verification
Two events can fall in the same cycle. The first is the completion pulse together with acceptance of the next request: `busy` drops in the pulse cycle, so a `req_valid` that is already waiting is taken on that edge. The second is the handshake of one command together with the loading of the next command or of the pulse. The bench provokes the first case by presenting a new request in the very cycle the pulse is seen. It judges that case by requiring `busy` high and the second request's commands to follow in full. The second case is covered by running requests with the engine always ready, ready on alternate cycles and ready one cycle in four. In each run, every handshaken command is compared with an independently computed list, and the pulse must fall exactly one cycle after the last handshake.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_FLUSH_ALIAS = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    CK_LINE      = 2'd0,
    CK_CLEAN_RNG = 2'd1,
    CK_INV_RNG   = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/sp_edge_prep.sv
module sp_edge_prep import sp_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 5
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] s_in,
  input  logic [ADDR_W-1:0] e_in,
  input  logic              wt,
  output logic              head_pend,
  output logic [ADDR_W-1:0] head_addr,
  output logic              tail_pend,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [ADDR_W:0]   run_s,
  output logic [ADDR_W:0]   run_e,
  output logic              do_clean,
  output logic              do_inv
);
  localparam int EW = ADDR_W + 1;
  localparam logic [EW-1:0] LINE_E = EW'(1) << LINE_LG;

  logic [ADDR_W-1:0] s_al, e_al;
  logic              s_off, e_off;
  logic [EW-1:0]     s_next;

  assign s_al  = {s_in[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
  assign e_al  = {e_in[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
  assign s_off = |s_in[LINE_LG-1:0];
  assign e_off = |e_in[LINE_LG-1:0];
  assign s_next = s_off ? ({1'b0, s_al} + LINE_E) : {1'b0, s_in};
  assign head_addr = s_al;
  assign tail_addr = e_al;

  always_comb begin
    if (op == OP_INV) begin
      // partial edge lines handled singly, whole lines in between by range
      head_pend = s_off;
      tail_pend = e_off && (s_next < {1'b0, e_in});
      run_s     = s_next;
      run_e     = tail_pend ? {1'b0, e_al} : {1'b0, e_in};
      do_clean  = 1'b0;
      do_inv    = 1'b1;
    end else begin
      // clean / flush widen outward to line boundaries
      head_pend = 1'b0;
      tail_pend = 1'b0;
      run_s     = {1'b0, s_al};
      run_e     = e_off ? ({1'b0, e_al} + LINE_E) : {1'b0, e_in};
      do_clean  = !wt;
      do_inv    = (op != OP_CLEAN);
    end
  end
endmodule

// File: rtl/sp_chunk_bound.sv
module sp_chunk_bound #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LG  = 5,
  parameter int CHUNK_LG = 10,
  parameter int PAGE_LG  = 12
) (
  input  logic [ADDR_W:0]   cur_s,
  input  logic [ADDR_W:0]   cur_e,
  output logic [ADDR_W:0]   nxt,
  output logic [ADDR_W-1:0] last
);
  localparam int EW = ADDR_W + 1;
  localparam logic [EW-1:0] CHUNK_E = EW'(1) << CHUNK_LG;
  localparam logic [EW-1:0] PAGE_E  = EW'(1) << PAGE_LG;
  localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(1) << LINE_LG;

  logic [EW-1:0] cap_end, page_end;

  assign cap_end  = cur_s + CHUNK_E;
  assign page_end = {cur_s[EW-1:PAGE_LG], {PAGE_LG{1'b0}}} + PAGE_E;

  always_comb begin
    nxt = cur_e;
    if (nxt > cap_end)  nxt = cap_end;
    if (nxt > page_end) nxt = page_end;
  end

  assign last = nxt[ADDR_W-1:0] - LINE_A;
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter import sp_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_last,
  output logic              done_pulse
);
  localparam int LINE_LG  = $clog2(LINE_BYTES);
  localparam int CHUNK_LG = $clog2(CHUNK_BYTES);
  localparam int PAGE_LG  = $clog2(PAGE_BYTES);
  localparam int EW       = ADDR_W + 1;

  // edge preparation outputs
  logic              p_head, p_tail, p_clean, p_inv;
  logic [ADDR_W-1:0] p_head_a, p_tail_a;
  logic [EW-1:0]     p_s, p_e;

  // request state
  logic              head_q, tail_q, clean_q, inv_q, clean_sent_q;
  logic [ADDR_W-1:0] head_a_q, tail_a_q;
  logic [EW-1:0]     cur_s, cur_e;

  // chunk bound
  logic [EW-1:0]     c_nxt;
  logic [ADDR_W-1:0] c_last;

  logic slot_free, range_left;

  sp_edge_prep #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_edge (
    .op(req_op), .s_in(req_start), .e_in(req_end), .wt(wt_override),
    .head_pend(p_head), .head_addr(p_head_a),
    .tail_pend(p_tail), .tail_addr(p_tail_a),
    .run_s(p_s), .run_e(p_e), .do_clean(p_clean), .do_inv(p_inv)
  );

  sp_chunk_bound #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG),
                   .CHUNK_LG(CHUNK_LG), .PAGE_LG(PAGE_LG)) u_chunk (
    .cur_s(cur_s), .cur_e(cur_e), .nxt(c_nxt), .last(c_last)
  );

  assign slot_free  = !cmd_valid || cmd_ready;
  assign range_left = (clean_q || inv_q) && (cur_s < cur_e);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      cmd_valid    <= 1'b0;
      cmd_kind     <= CK_LINE;
      cmd_addr     <= '0;
      cmd_last     <= '0;
      done_pulse   <= 1'b0;
      head_q       <= 1'b0;
      tail_q       <= 1'b0;
      clean_q      <= 1'b0;
      inv_q        <= 1'b0;
      clean_sent_q <= 1'b0;
      head_a_q     <= '0;
      tail_a_q     <= '0;
      cur_s        <= '0;
      cur_e        <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy         <= 1'b1;
          head_q       <= p_head;
          tail_q       <= p_tail;
          head_a_q     <= p_head_a;
          tail_a_q     <= p_tail_a;
          cur_s        <= p_s;
          cur_e        <= p_e;
          clean_q      <= p_clean;
          inv_q        <= p_inv;
          clean_sent_q <= 1'b0;
        end
      end else if (slot_free) begin
        if (head_q) begin
          cmd_valid <= 1'b1;
          cmd_kind  <= CK_LINE;
          cmd_addr  <= head_a_q;
          cmd_last  <= head_a_q;
          head_q    <= 1'b0;
        end else if (tail_q) begin
          cmd_valid <= 1'b1;
          cmd_kind  <= CK_LINE;
          cmd_addr  <= tail_a_q;
          cmd_last  <= tail_a_q;
          tail_q    <= 1'b0;
        end else if (range_left) begin
          cmd_valid <= 1'b1;
          cmd_addr  <= cur_s[ADDR_W-1:0];
          cmd_last  <= c_last;
          if (clean_q && !clean_sent_q) begin
            cmd_kind <= CK_CLEAN_RNG;
            if (inv_q) clean_sent_q <= 1'b1;
            else       cur_s        <= c_nxt;
          end else begin
            cmd_kind     <= CK_INV_RNG;
            clean_sent_q <= 1'b0;
            cur_s        <= c_nxt;
          end
        end else begin
          cmd_valid  <= 1'b0;
          busy       <= 1'b0;
          done_pulse <= 1'b1;
        end
      end
    end
  end

  // R1
  cmd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                   $stable(cmd_addr) && $stable(cmd_last)));

  // R6
  chunk_size_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind != CK_LINE) |->
      (cmd_last >= cmd_addr && (cmd_last - cmd_addr) < ADDR_W'(CHUNK_BYTES)));

  // R7
  chunk_page_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind != CK_LINE) |->
      ((cmd_addr >> PAGE_LG) == (cmd_last >> PAGE_LG)));

  // R5
  line_align_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr[LINE_LG-1:0] == '0 && cmd_last[LINE_LG-1:0] == '0));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (!busy && !cmd_valid));
endmodule

// File: tb/sim_cache_range_splitter.sv
module sim_cache_range_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_start = '0, req_end = '0;
  logic        wt_override = 1'b0;
  logic        busy, cmd_valid, done_pulse;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_addr, cmd_last;

  always #10 clk = ~clk;

  cache_range_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last(cmd_last),
    .done_pulse(done_pulse)
  );

  int n_chk = 0, n_bad = 0;
  int exp_k[64];
  longint exp_a[64], exp_l[64];
  int exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic longint cend(input longint s, input longint e);
    longint r = e;
    if (r > s + 1024) r = s + 1024;
    if (r > (s | 4095) + 1) r = (s | 4095) + 1;
    return r;
  endfunction

  task automatic add_exp(input int k, input longint a, input longint l);
    if (exp_n < 64) begin
      exp_k[exp_n] = k; exp_a[exp_n] = a; exp_l[exp_n] = l;
    end
    exp_n++;
  endtask

  task automatic build_exp(input int op, input longint s0, input longint e0, input bit wt);
    longint s = s0, e = e0, r;
    exp_n = 0;
    if (op == 0) begin
      if ((s & 31) != 0) begin add_exp(0, s & ~64'd31, s & ~64'd31); s = (s | 31) + 1; end
      if (s < e && (e & 31) != 0) begin add_exp(0, e & ~64'd31, e & ~64'd31); e = e & ~64'd31; end
      while (s < e) begin r = cend(s, e); add_exp(2, s, r - 32); s = r; end
    end else begin
      s = s & ~64'd31;
      e = (e + 31) & ~64'd31;
      while (s < e) begin
        r = cend(s, e);
        if (!wt) add_exp(1, s, r - 32);
        if (op != 1) add_exp(2, s, r - 32);
        s = r;
      end
      if (op == 1 && wt) exp_n = 0;
    end
  endtask

  task automatic drive(input int op, input longint s, input longint e, input bit wt);
    build_exp(op, s, e, wt);
    req_op = op[1:0]; req_start = s[31:0]; req_end = e[31:0];
    wt_override = wt; req_valid = 1'b1;
  endtask

  // Called right after drive(); returns on the negedge where done_pulse is seen.
  task automatic monitor(input int mode, input bit poke, input string tag);
    int idx = 0, hs_cyc = 0;
    bit prev_stall = 0, finished = 0;
    logic [1:0] pk = '0;
    logic [31:0] pa = '0, pl = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (mode == 0) cmd_ready = 1'b1;
      else if (mode == 1) cmd_ready = (cyc % 2 == 1);
      else cmd_ready = (cyc % 4 == 3);
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_op = 2'd1; req_start = 32'h9000; req_end = 32'h9400;
      end else if (poke && cyc == 3) req_valid = 1'b0;
      if (done_pulse) begin
        chk(idx == exp_n, "R12", {tag, " command count"}, idx, exp_n);
        chk(cyc == hs_cyc + 1, "R10", {tag, " barrier cycle"}, cyc, hs_cyc + 1);
        chk(busy == 1'b0, "R1", {tag, " busy at barrier"}, busy, 0);
        finished = 1;
        break;
      end
      if (busy != 1'b1) chk(0, "R1", {tag, " busy dropped early"}, busy, 1);
      if (prev_stall)
        chk(cmd_valid && cmd_kind == pk && cmd_addr == pa && cmd_last == pl,
            "R11", {tag, " payload held"}, cmd_addr, pa);
      if (cmd_valid && cmd_ready) begin
        if (idx < exp_n && idx < 64) begin
          chk(cmd_kind == exp_k[idx][1:0], tag, $sformatf("cmd %0d kind", idx), cmd_kind, exp_k[idx]);
          chk(cmd_addr == exp_a[idx][31:0], tag, $sformatf("cmd %0d addr", idx), cmd_addr, exp_a[idx]);
          chk(cmd_last == exp_l[idx][31:0], tag, $sformatf("cmd %0d last", idx), cmd_last, exp_l[idx]);
        end else
          chk(0, "R12", {tag, " extra command"}, cmd_addr, 0);
        idx++;
        hs_cyc = cyc;
      end
      prev_stall = cmd_valid && !cmd_ready;
      pk = cmd_kind; pa = cmd_addr; pl = cmd_last;
      @(negedge clk);
    end
    if (!finished) chk(0, "R10", {tag, " no barrier"}, 0, 1);
    cmd_ready = 1'b0;
  endtask

  task automatic run(input int op, input longint s, input longint e, input bit wt,
                     input int mode, input string tag);
    @(negedge clk);
    drive(op, s, e, wt);
    monitor(mode, 0, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(cmd_valid == 0, "R11", "reset cmd_valid", cmd_valid, 0);
    chk(done_pulse == 0, "R10", "reset done", done_pulse, 0);
    rst = 1'b0;
  endtask

  task automatic t_inv_edges();     run(0, 'h1004, 'h1234, 0, 0, "R3 R4 R12 inv edges"); endtask
  task automatic t_inv_tiny();      run(0, 'h44, 'h48, 0, 1, "R3 R4 inv inside one line"); endtask
  task automatic t_inv_long();      run(0, 'h0, 'h1800, 0, 2, "R6 R7 inv long"); endtask
  task automatic t_clean_page();    run(1, 'hE10, 'h20F1, 0, 1, "R5 R6 R7 clean"); endtask
  task automatic t_flush();         run(2, 'h3F9, 'h805, 0, 2, "R9 R5 flush"); endtask
  task automatic t_flush_wt();      run(2, 'h3F9, 'h805, 1, 0, "R8 flush override"); endtask
  task automatic t_clean_wt();      run(1, 'h100, 'h900, 1, 1, "R8 R10 clean override"); endtask
  task automatic t_empty_inv();     run(0, 'h200, 'h200, 0, 0, "R10 empty inv"); endtask
  task automatic t_op3();           run(3, 'h10, 'h30, 0, 0, "R2 op code 3"); endtask

  task automatic t_poke();
    @(negedge clk);
    drive(0, 'h4000, 'h5000, 0);
    monitor(2, 1, "R1 R7 request while busy");
    @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R1", "request during busy was taken", busy, 0);
    chk(cmd_valid == 0, "R1", "stray command after poke", cmd_valid, 0);
  endtask

  task automatic t_chain();
    @(negedge clk);
    drive(1, 'h80, 'hA0, 0);
    monitor(0, 0, "R10 chain first");
    drive(0, 'h61, 'h7F, 0);
    monitor(1, 0, "R1 R10 chain second");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: got 150000 cycles expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_inv_edges();
    t_inv_tiny();
    t_inv_long();
    t_clean_page();
    t_flush();
    t_flush_wt();
    t_clean_wt();
    t_empty_inv();
    t_op3();
    t_poke();
    t_chain();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule